// File: doc/BRIEF.md
# NOR Flash Command Sequence Controller

This block is the command front end of a small NOR-style flash macro. A host drives chip enable, output enable, write enable, an address and a data byte. The block samples these on its system clock and turns multi-write command sequences into program and erase operations on a small on-chip byte array. An erased byte holds 0xFF. Program and erase each take a fixed number of clock cycles set by a parameter, and a ready output is low while either one runs.

A write is taken on the clock edge that first sees write enable low with chip enable low. A read start is taken on the edge that first sees output enable low with chip enable low. Reads are combinational from the selected source: the array, the identification register, or the operation status. A separate active-low hardware reset input aborts any operation and returns the block to array reads. After that reset, ready stays low for a fixed time if an operation was aborted. If nothing was running, access is blocked for a shorter time.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After `rst_ni` deasserts, ready_o is 1, every byte reads 0xFF, and plain reads return array data with no command written.
- R2: data_oe_o is 1 only when ce_ni=0, oe_ni=0, we_ni=1, hw_rst_ni=1 and no reset hold time is pending. When data_oe_o is 0, data_o is 0x00.
- R3: A standard program takes four writes: 0xAA at unlock address A1, 0x55 at unlock address A2, 0xA0 at A1, then the data at its target. A1 is 0x555 and A2 is 0x2AA, both truncated to AW bits. The stored byte becomes old AND data.
- R4: The write sequence AA@A1, 55@A2, 20@A1 enters bypass mode. In bypass mode, a write of 0xA0 (any address) followed by the data write programs one byte, and the block stays in bypass mode. Reads in bypass mode return array data. Any other write in bypass mode returns the block to array reads.
- R5: The write sequence AA@A1, 55@A2, 90@A1 enters identification mode. Reads then return MFR_ID when addr[1:0]=0, DEV_ID when addr[1:0]=1, and 0x00 otherwise. Any write leaves this mode.
- R6: The erase prefix is AA@A1, 55@A2, 80@A1, AA@A1, 55@A2. After it, 0x30 written at an address marks the sector selected by the top SB address bits. Each further 0x30 write within SECT_WIN cycles of the previous one adds its sector. When the window closes, the marked sectors are set to 0xFF and all other bytes are unchanged.
- R7: The erase prefix followed by 0x10 at A1 sets every byte to 0xFF.
- R8: ready_o is low for exactly PROG_CYC cycles after the program data write and for exactly ERASE_CYC cycles after a chip-erase command. Writes during that time have no effect. Deselecting the chip does not stop the operation.
- R9: While an operation runs or a sector window is open, reads return status. Bit 7 is the complement of bit 7 of the data being stored (0 for erase). Bit 6 inverts on every read start. Bits 5:0 are 0.
- R10: A write that does not fit the current sequence step, including 0xF0, returns the block to array reads, and a program attempted after it has no effect.
- R11: While hw_rst_ni is 0, data_oe_o is 0 and writes are ignored. The running operation is dropped without changing the array, and array reads resume afterwards.
- R12: If an operation or sector window was active when hw_rst_ni falls, ready_o stays low for RST_BUSY_CYC cycles from that fall. Otherwise ready_o stays 1 and bus access is blocked for RST_IDLE_CYC cycles from the fall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous power-on reset, active low |
| hw_rst_ni | input | 1 | Bus hardware reset, active low, sampled on clk_i |
| ce_ni | input | 1 | Chip enable, active low |
| oe_ni | input | 1 | Output enable, active low |
| we_ni | input | 1 | Write enable, active low |
| addr_i | input | AW | Byte address |
| data_i | input | 8 | Write data / command byte |
| data_o | output | 8 | Read data |
| data_oe_o | output | 1 | Data bus drive enable (0 = high impedance) |
| ready_o | output | 1 | 1 = ready, 0 = busy |

## Verification
The bench builds the block with AW=8, SB=2, PROG_CYC=8, ERASE_CYC=40, SECT_WIN=8, RST_BUSY_CYC=20 and RST_IDLE_CYC=4. These short counts let it measure program and chip-erase busy lengths exactly, cycle by cycle. They also leave room to read status twice inside one program, to open a two-sector erase window, and to cut a chip erase with a reset part-way through. The 256-byte array with four sectors makes sector boundaries cheap to probe at 0x05, 0x45, 0x85 and 0xC5. With 8-bit addresses, the unlock addresses become 0x55 and 0xAA.

// File: rtl/flash_ctl_pkg.sv
package flash_ctl_pkg;

  typedef enum logic [3:0] {
    S_READ, S_UNL1, S_UNL2, S_PROG, S_ESET, S_EUN1,
    S_EUN2, S_SWIN, S_ASEL, S_BYP, S_BPROG, S_BUSY
  } seq_state_t;

  typedef enum logic [1:0] {RM_ARRAY, RM_ID, RM_STAT} rd_mode_t;

  localparam logic [7:0] CMD_UNL1 = 8'hAA;
  localparam logic [7:0] CMD_UNL2 = 8'h55;
  localparam logic [7:0] CMD_PROG = 8'hA0;
  localparam logic [7:0] CMD_BYP  = 8'h20;
  localparam logic [7:0] CMD_ASEL = 8'h90;
  localparam logic [7:0] CMD_ESET = 8'h80;
  localparam logic [7:0] CMD_CHIP = 8'h10;
  localparam logic [7:0] CMD_SECT = 8'h30;

endpackage

// File: rtl/flash_seq.sv
module flash_seq
  import flash_ctl_pkg::*;
#(
  parameter int AW       = 8,
  parameter int SB       = 2,
  parameter int SECT_WIN = 32,
  localparam int NSECT   = 1 << SB,
  localparam int WW      = $clog2(SECT_WIN + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             abort_i,
  input  logic             wr_i,
  input  logic [AW-1:0]    waddr_i,
  input  logic [7:0]       wdata_i,
  input  logic             eng_done_i,
  output logic             prog_go_o,
  output logic             erase_go_o,
  output logic [NSECT-1:0] erase_mask_o,
  output rd_mode_t         rd_mode_o,
  output logic             win_o
);

  localparam logic [AW-1:0] UA1 = AW'(12'h555);
  localparam logic [AW-1:0] UA2 = AW'(12'h2AA);

  seq_state_t       state_q;
  logic             ret_byp_q;
  logic [NSECT-1:0] mask_q;
  logic [WW-1:0]    win_q;

  logic             is_u1, is_u2, sect_wr, chip_go, win_end;
  logic [NSECT-1:0] sec_1h;

  assign is_u1   = wr_i && waddr_i == UA1 && wdata_i == CMD_UNL1;
  assign is_u2   = wr_i && waddr_i == UA2 && wdata_i == CMD_UNL2;
  assign sect_wr = wr_i && wdata_i == CMD_SECT;
  assign sec_1h  = NSECT'(1) << waddr_i[AW-1 -: SB];
  assign chip_go = wr_i && state_q == S_EUN2 && waddr_i == UA1 && wdata_i == CMD_CHIP;
  assign win_end = state_q == S_SWIN && !sect_wr && win_q == WW'(1);

  assign prog_go_o    = !abort_i && wr_i && (state_q == S_PROG || state_q == S_BPROG);
  assign erase_go_o   = !abort_i && (chip_go || win_end);
  assign erase_mask_o = chip_go ? '1 : mask_q;
  assign win_o        = state_q == S_SWIN;

  always_comb begin
    unique case (state_q)
      S_SWIN, S_BUSY: rd_mode_o = RM_STAT;
      S_ASEL:         rd_mode_o = RM_ID;
      default:        rd_mode_o = RM_ARRAY;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= S_READ;
      ret_byp_q <= 1'b0;
      mask_q    <= '0;
      win_q     <= '0;
    end else if (abort_i) begin
      state_q   <= S_READ;
      ret_byp_q <= 1'b0;
      mask_q    <= '0;
      win_q     <= '0;
    end else begin
      unique case (state_q)
        S_READ: if (is_u1) state_q <= S_UNL1;
        S_UNL1: if (wr_i) state_q <= is_u2 ? S_UNL2 : S_READ;
        S_UNL2: if (wr_i) begin
          state_q <= S_READ;
          if (waddr_i == UA1) begin
            unique case (wdata_i)
              CMD_PROG: state_q <= S_PROG;
              CMD_BYP:  state_q <= S_BYP;
              CMD_ASEL: state_q <= S_ASEL;
              CMD_ESET: state_q <= S_ESET;
              default:  state_q <= S_READ;
            endcase
          end
        end
        S_PROG: if (wr_i) begin
          state_q   <= S_BUSY;
          ret_byp_q <= 1'b0;
        end
        S_ESET: if (wr_i) state_q <= is_u1 ? S_EUN1 : S_READ;
        S_EUN1: if (wr_i) state_q <= is_u2 ? S_EUN2 : S_READ;
        S_EUN2: if (wr_i) begin
          if (chip_go) begin
            state_q   <= S_BUSY;
            ret_byp_q <= 1'b0;
          end else if (sect_wr) begin
            state_q <= S_SWIN;
            mask_q  <= sec_1h;
            win_q   <= WW'(SECT_WIN);
          end else begin
            state_q <= S_READ;
          end
        end
        S_SWIN: begin
          if (sect_wr) begin
            mask_q <= mask_q | sec_1h;
            win_q  <= WW'(SECT_WIN);
          end else if (win_end) begin
            state_q   <= S_BUSY;
            ret_byp_q <= 1'b0;
          end else begin
            win_q <= win_q - WW'(1);
          end
        end
        S_ASEL: if (wr_i) state_q <= S_READ;
        S_BYP:  if (wr_i) state_q <= (wdata_i == CMD_PROG) ? S_BPROG : S_READ;
        S_BPROG: if (wr_i) begin
          state_q   <= S_BUSY;
          ret_byp_q <= 1'b1;
        end
        S_BUSY: if (eng_done_i) state_q <= ret_byp_q ? S_BYP : S_READ;
        default: state_q <= S_READ;
      endcase
    end
  end

  assert_abort_read_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_i |=> state_q == S_READ);

  assert_busy_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == S_BUSY && !eng_done_i && !abort_i |=> state_q == S_BUSY);

  assert_byp_return_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == S_BUSY && ret_byp_q && eng_done_i && !abort_i |=> state_q == S_BYP);

endmodule

// File: rtl/flash_engine.sv
module flash_engine #(
  parameter int AW        = 8,
  parameter int SB        = 2,
  parameter int PROG_CYC  = 16,
  parameter int ERASE_CYC = 256,
  localparam int NSECT    = 1 << SB,
  localparam int DEPTH    = 1 << AW,
  localparam int SSH      = AW - SB,
  localparam int CMAX     = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC,
  localparam int CW       = $clog2(CMAX + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             abort_i,
  input  logic             prog_go_i,
  input  logic             erase_go_i,
  input  logic [NSECT-1:0] mask_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [7:0]       data_i,
  input  logic [AW-1:0]    rd_addr_i,
  output logic [7:0]       rd_data_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             stat_b7_o
);

  logic [7:0]       mem [DEPTH];
  logic [CW-1:0]    cnt_q;
  logic             busy_q, is_prog_q;
  logic [AW-1:0]    addr_q;
  logic [7:0]       data_q;
  logic [NSECT-1:0] mask_q;
  logic [DEPTH-1:0] ers_hit;

  for (genvar g = 0; g < DEPTH; g++) begin : g_sect
    localparam int SI = g >> SSH;
    assign ers_hit[g] = mask_q[SI];
  end

  assign done_o    = busy_q && cnt_q == CW'(1);
  assign busy_o    = busy_q;
  assign stat_b7_o = is_prog_q ? ~data_q[7] : 1'b0;
  assign rd_data_o = mem[rd_addr_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q    <= 1'b0;
      cnt_q     <= '0;
      is_prog_q <= 1'b0;
      addr_q    <= '0;
      data_q    <= '0;
      mask_q    <= '0;
    end else if (abort_i) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (prog_go_i) begin
      busy_q    <= 1'b1;
      cnt_q     <= CW'(PROG_CYC);
      is_prog_q <= 1'b1;
      addr_q    <= addr_i;
      data_q    <= data_i;
    end else if (erase_go_i) begin
      busy_q    <= 1'b1;
      cnt_q     <= CW'(ERASE_CYC);
      is_prog_q <= 1'b0;
      mask_q    <= mask_i;
    end else if (busy_q) begin
      cnt_q <= cnt_q - CW'(1);
      if (done_o) busy_q <= 1'b0;
    end
  end

  // array commits only at completion, so an abort leaves it untouched
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
    end else if (done_o && !abort_i) begin
      for (int i = 0; i < DEPTH; i++) begin
        if (!is_prog_q && ers_hit[i]) mem[i] <= 8'hFF;
        else if (is_prog_q && addr_q == AW'(i)) mem[i] <= mem[i] & data_q;
      end
    end
  end

  assert_prog_and_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && is_prog_q && !abort_i |=> mem[$past(addr_q)] == ($past(mem[addr_q]) & $past(data_q)));

  assert_erase_ff_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !is_prog_q && mask_q[0] && !abort_i |=> mem[0] == 8'hFF);

  assert_busy_run_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && !done_o && !abort_i && !prog_go_i && !erase_go_i |=> busy_q);

endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import flash_ctl_pkg::*;
#(
  parameter int         AW           = 8,
  parameter int         SB           = 2,
  parameter int         PROG_CYC     = 16,
  parameter int         ERASE_CYC    = 256,
  parameter int         SECT_WIN     = 32,
  parameter int         RST_BUSY_CYC = 64,
  parameter int         RST_IDLE_CYC = 8,
  parameter logic [7:0] MFR_ID       = 8'h37,
  parameter logic [7:0] DEV_ID       = 8'hB5,
  localparam int        NSECT        = 1 << SB,
  localparam int        RMAX         = (RST_BUSY_CYC > RST_IDLE_CYC) ? RST_BUSY_CYC : RST_IDLE_CYC,
  localparam int        RW           = $clog2(RMAX + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          hw_rst_ni,
  input  logic          ce_ni,
  input  logic          oe_ni,
  input  logic          we_ni,
  input  logic [AW-1:0] addr_i,
  input  logic [7:0]    data_i,
  output logic [7:0]    data_o,
  output logic          data_oe_o,
  output logic          ready_o
);

  logic             we_q, oe_q, hw_q, tog_q, rst_busy_q;
  logic [RW-1:0]    rst_cnt_q;
  logic             acc_ok, wr_ev, rd_ev, abort, op_active;
  logic             prog_go, erase_go, eng_busy, eng_done, eng_b7, win;
  logic [NSECT-1:0] erase_mask;
  logic [7:0]       arr_data, id_data, rd_val;
  rd_mode_t         rd_mode;

  assign abort     = !hw_rst_ni;
  assign acc_ok    = hw_rst_ni && rst_cnt_q == '0;
  assign wr_ev     = acc_ok && !ce_ni && !we_ni && we_q;
  assign rd_ev     = acc_ok && !ce_ni && !oe_ni && oe_q;
  assign op_active = eng_busy || win;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      we_q       <= 1'b1;
      oe_q       <= 1'b1;
      hw_q       <= 1'b1;
      tog_q      <= 1'b0;
      rst_busy_q <= 1'b0;
      rst_cnt_q  <= '0;
    end else begin
      we_q <= we_ni;
      oe_q <= oe_ni;
      hw_q <= hw_rst_ni;
      if (rd_ev) tog_q <= ~tog_q;
      if (hw_q && !hw_rst_ni) begin
        rst_cnt_q  <= op_active ? RW'(RST_BUSY_CYC) : RW'(RST_IDLE_CYC);
        rst_busy_q <= op_active;
      end else if (rst_cnt_q != '0) begin
        rst_cnt_q <= rst_cnt_q - RW'(1);
      end
    end
  end

  flash_seq #(.AW(AW), .SB(SB), .SECT_WIN(SECT_WIN)) seq_i (
    .clk_i, .rst_ni, .abort_i(abort), .wr_i(wr_ev), .waddr_i(addr_i), .wdata_i(data_i),
    .eng_done_i(eng_done), .prog_go_o(prog_go), .erase_go_o(erase_go),
    .erase_mask_o(erase_mask), .rd_mode_o(rd_mode), .win_o(win)
  );

  flash_engine #(.AW(AW), .SB(SB), .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)) eng_i (
    .clk_i, .rst_ni, .abort_i(abort), .prog_go_i(prog_go), .erase_go_i(erase_go),
    .mask_i(erase_mask), .addr_i(addr_i), .data_i(data_i), .rd_addr_i(addr_i),
    .rd_data_o(arr_data), .busy_o(eng_busy), .done_o(eng_done), .stat_b7_o(eng_b7)
  );

  always_comb begin
    unique case (addr_i[1:0])
      2'd0:    id_data = MFR_ID;
      2'd1:    id_data = DEV_ID;
      default: id_data = 8'h00;
    endcase
  end

  always_comb begin
    unique case (rd_mode)
      RM_STAT: rd_val = {eng_busy ? eng_b7 : 1'b0, tog_q, 6'b0};
      RM_ID:   rd_val = id_data;
      default: rd_val = arr_data;
    endcase
  end

  assign data_oe_o = acc_ok && !ce_ni && !oe_ni && we_ni;
  assign data_o    = data_oe_o ? rd_val : 8'h00;
  assign ready_o   = !op_active && !(rst_busy_q && rst_cnt_q != '0);

  assert_rst_busy_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hw_q && !hw_rst_ni && op_active |=> !ready_o);

  assert_rst_idle_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hw_q && !hw_rst_ni && !op_active |=> ready_o);

  assert_tog_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_ev |=> tog_q != $past(tog_q));

endmodule

// File: tb/flash_cmd_ctrl_tb_top.sv
module flash_cmd_ctrl_tb_top;

  localparam int PROG_CYC = 8, ERASE_CYC = 40, RB = 20, RI = 4;

  logic       clk = 1'b0, rst_n = 1'b0, hw_n = 1'b1;
  logic       ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic [7:0] addr = '0, din = '0, dout;
  logic       doe, rdy;
  int         checks = 0, fails = 0;
  bit         finished = 1'b0;

  always #10 clk = ~clk;

  flash_cmd_ctrl #(
    .AW(8), .SB(2), .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC), .SECT_WIN(8),
    .RST_BUSY_CYC(RB), .RST_IDLE_CYC(RI), .MFR_ID(8'h37), .DEV_ID(8'hB5)
  ) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .hw_rst_ni(hw_n), .ce_ni(ce_n), .oe_ni(oe_n),
    .we_ni(we_n), .addr_i(addr), .data_i(din), .data_o(dout), .data_oe_o(doe), .ready_o(rdy)
  );

  // {req[3:0], kind[1:0] 0=write 1=read, addr, data, expect}
  localparam int NV = 42;
  localparam logic [29:0] VEC [NV] = '{
    {4'd1, 2'd1, 8'h10, 8'h00, 8'hFF},                                      // R1
    {4'd3, 2'd0, 8'h55, 8'hAA, 8'h00}, {4'd3, 2'd0, 8'hAA, 8'h55, 8'h00},
    {4'd3, 2'd0, 8'h55, 8'hA0, 8'h00}, {4'd3, 2'd0, 8'h10, 8'h3C, 8'h00},
    {4'd3, 2'd1, 8'h10, 8'h00, 8'h3C},                                      // R3
    {4'd3, 2'd0, 8'h55, 8'hAA, 8'h00}, {4'd3, 2'd0, 8'hAA, 8'h55, 8'h00},
    {4'd3, 2'd0, 8'h55, 8'hA0, 8'h00}, {4'd3, 2'd0, 8'h10, 8'hF0, 8'h00},
    {4'd3, 2'd1, 8'h10, 8'h00, 8'h30},                                      // R3 AND
    {4'd5, 2'd0, 8'h55, 8'hAA, 8'h00}, {4'd5, 2'd0, 8'hAA, 8'h55, 8'h00},
    {4'd5, 2'd0, 8'h55, 8'h90, 8'h00},
    {4'd5, 2'd1, 8'h00, 8'h00, 8'h37}, {4'd5, 2'd1, 8'h01, 8'h00, 8'hB5},   // R5
    {4'd5, 2'd1, 8'h02, 8'h00, 8'h00}, {4'd5, 2'd1, 8'h03, 8'h00, 8'h00},
    {4'd10, 2'd0, 8'h00, 8'hF0, 8'h00},
    {4'd10, 2'd1, 8'h10, 8'h00, 8'h30},                                     // R10
    {4'd10, 2'd0, 8'h55, 8'hAA, 8'h00}, {4'd10, 2'd0, 8'h33, 8'h77, 8'h00},
    {4'd10, 2'd0, 8'hAA, 8'h55, 8'h00}, {4'd10, 2'd0, 8'h55, 8'hA0, 8'h00},
    {4'd10, 2'd0, 8'h11, 8'h00, 8'h00},
    {4'd10, 2'd1, 8'h11, 8'h00, 8'hFF},                                     // R10
    {4'd6, 2'd0, 8'h55, 8'hAA, 8'h00}, {4'd6, 2'd0, 8'hAA, 8'h55, 8'h00},
    {4'd6, 2'd0, 8'h55, 8'hA0, 8'h00}, {4'd6, 2'd0, 8'h45, 8'h00, 8'h00},
    {4'd6, 2'd0, 8'h55, 8'hAA, 8'h00}, {4'd6, 2'd0, 8'hAA, 8'h55, 8'h00},
    {4'd6, 2'd0, 8'h55, 8'hA0, 8'h00}, {4'd6, 2'd0, 8'h05, 8'h00, 8'h00},
    {4'd6, 2'd0, 8'h55, 8'hAA, 8'h00}, {4'd6, 2'd0, 8'hAA, 8'h55, 8'h00},
    {4'd6, 2'd0, 8'h55, 8'h80, 8'h00}, {4'd6, 2'd0, 8'h55, 8'hAA, 8'h00},
    {4'd6, 2'd0, 8'hAA, 8'h55, 8'h00}, {4'd6, 2'd0, 8'h45, 8'h30, 8'h00},
    {4'd6, 2'd1, 8'h45, 8'h00, 8'hFF}, {4'd6, 2'd1, 8'h05, 8'h00, 8'h00}    // R6
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; din = d; ce_n = 1'b0; we_n = 1'b0;
    @(negedge clk); we_n = 1'b1; ce_n = 1'b1;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; ce_n = 1'b0; oe_n = 1'b0;
    @(negedge clk); d = dout; oe_n = 1'b1; ce_n = 1'b1;
  endtask

  task automatic wait_ready(output int n);
    n = 0;
    while (rdy !== 1'b1 && n < 100000) begin n++; @(negedge clk); end
  endtask

  task automatic erase_pre();
    wr(8'h55, 8'hAA); wr(8'hAA, 8'h55); wr(8'h55, 8'h80);
    wr(8'h55, 8'hAA); wr(8'hAA, 8'h55);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    logic [7:0] v, s1, s2;
    int n, bad;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ready after reset", {7'd0, rdy}, 8'd1);
    chk("R2 idle bus hi-z", {7'd0, doe}, 8'd0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][25:24] == 2'd0) begin
        wr(VEC[i][23:16], VEC[i][15:8]);
        wait_ready(n);
      end else begin
        rd(VEC[i][23:16], v);
        chk($sformatf("R%0d vector %0d", VEC[i][29:26], i), v, VEC[i][7:0]);
      end
    end

    // R2 enable gating
    @(negedge clk); ce_n = 1'b1; oe_n = 1'b0;
    @(negedge clk); chk("R2 ce high", {7'd0, doe}, 8'd0);
    ce_n = 1'b0; oe_n = 1'b1;
    @(negedge clk); chk("R2 oe high", {7'd0, doe}, 8'd0);
    oe_n = 1'b0;
    @(negedge clk); chk("R2 both low", {7'd0, doe}, 8'd1);
    ce_n = 1'b1; oe_n = 1'b1;

    // R4 bypass program, R8 busy length
    wr(8'h55, 8'hAA); wr(8'hAA, 8'h55); wr(8'h55, 8'h20);
    wr(8'h20, 8'hA0); wr(8'h20, 8'h0F);
    wait_ready(n);
    chk("R8 program busy cycles", 8'(n), 8'(PROG_CYC));
    rd(8'h20, v); chk("R4 bypass program", v, 8'h0F);
    wr(8'h21, 8'hA0); wr(8'h21, 8'h55); wait_ready(n);
    rd(8'h21, v); chk("R4 second bypass program", v, 8'h55);
    wr(8'h00, 8'h90); wr(8'h22, 8'hA0); wr(8'h22, 8'h00); wait_ready(n);
    rd(8'h22, v); chk("R4 bypass exited", v, 8'hFF);

    // R9 status during program, R8 write ignored while busy
    wr(8'h55, 8'hAA); wr(8'hAA, 8'h55); wr(8'h55, 8'hA0); wr(8'h30, 8'h00);
    rd(8'h30, s1); rd(8'h30, s2);
    chk("R9 bit7 complement", {7'd0, s1[7]}, 8'd1);
    chk("R9 bit6 toggles", {7'd0, s1[6] ^ s2[6]}, 8'd1);
    chk("R9 low bits zero", {2'd0, s1[5:0]}, 8'd0);
    wr(8'h31, 8'h00);
    wait_ready(n);
    rd(8'h31, v); chk("R8 write while busy ignored", v, 8'hFF);
    rd(8'h30, v); chk("R3 status-checked program", v, 8'h00);

    // R7 chip erase
    erase_pre(); wr(8'h55, 8'h10);
    wait_ready(n);
    chk("R8 erase busy cycles", 8'(n), 8'(ERASE_CYC));
    rd(8'h30, v); chk("R7 chip erase 30", v, 8'hFF);
    rd(8'h20, v); chk("R7 chip erase 20", v, 8'hFF);

    // R6 two-sector erase within window
    wr(8'h55, 8'hAA); wr(8'hAA, 8'h55); wr(8'h55, 8'h20);
    for (int k = 0; k < 4; k++) begin
      wr(8'h00, 8'hA0); wr(8'(8'h05 + 8'(k) * 8'h40), 8'h00); wait_ready(n);
    end
    wr(8'h00, 8'hF0);
    erase_pre(); wr(8'h45, 8'h30); wr(8'hC5, 8'h30);
    wait_ready(n);
    rd(8'h45, v); chk("R6 sector 1 erased", v, 8'hFF);
    rd(8'hC5, v); chk("R6 sector 3 erased", v, 8'hFF);
    rd(8'h05, v); chk("R6 sector 0 kept", v, 8'h00);
    rd(8'h85, v); chk("R6 sector 2 kept", v, 8'h00);

    // R11/R12 reset during chip erase
    wr(8'h55, 8'hAA); wr(8'hAA, 8'h55); wr(8'h55, 8'hA0); wr(8'h60, 8'h12); wait_ready(n);
    erase_pre(); wr(8'h55, 8'h10);
    repeat (10) @(negedge clk);
    hw_n = 1'b0; addr = 8'h60; ce_n = 1'b0; oe_n = 1'b0;
    bad = 0;
    for (int i = 0; i < RB + 2; i++) begin
      @(negedge clk);
      if (i == 0) chk("R11 hi-z in reset", {7'd0, doe}, 8'd0);
      if (i == 3) hw_n = 1'b1;
      if (rdy !== (i >= RB)) bad++;
    end
    ce_n = 1'b1; oe_n = 1'b1;
    chk("R12 busy reset timing mismatches", 8'(bad), 8'd0);
    rd(8'h60, v); chk("R11 abort keeps data, array mode", v, 8'h12);

    // R12 reset while idle
    @(negedge clk); hw_n = 1'b0;
    @(negedge clk); chk("R12 idle reset ready", {7'd0, rdy}, 8'd1);
    addr = 8'h60; ce_n = 1'b0; oe_n = 1'b0;
    @(negedge clk); hw_n = 1'b1;
    @(negedge clk);
    chk("R12 access blocked after idle reset", {7'd0, doe}, 8'd0);
    chk("R12 idle reset ready held", {7'd0, rdy}, 8'd1);
    @(negedge clk); @(negedge clk);
    chk("R12 access resumes", {7'd0, doe}, 8'd1);
    chk("R11 array read after reset", dout, 8'h12);
    ce_n = 1'b1; oe_n = 1'b1;

    finished = 1'b1;
    summary();
    $finish;
  end

endmodule